// File: doc/BRIEF.md
# DDR3 Command Timing Checker

This block tracks the recent command history of a DDR3 memory subsystem, per bank, per rank and across the whole channel. It answers one question: how many clock cycles remain before a candidate command to a given rank and bank would be legal. A command scheduler presents a candidate on the query port and reads back a delay in the same cycle. When it actually issues a command, it logs that command on the insert port.

The history is kept as saturating age counters, counting cycles since the last relevant command. The answer is the largest remaining wait across all rules that apply to the candidate. It is zero when the command may go out in the current cycle. All timing values are cycle-count parameters.

Command encoding on `insert_cmd` and `query_cmd`: 0 activate, 1 read, 2 read with auto-precharge, 3 write, 4 write with auto-precharge, 5 precharge one bank, 6 precharge all banks of a rank, 7 refresh all banks of a rank. Below, the write-recovery window WREC is tWL + BL/2 + tWR.

Top module: `ddr3_cmd_timer`

## Requirements
- R1: Directly after reset, every query returns a delay of 0, because a history entry that was never written imposes no constraint.
- R2: An activate (code 0) waits tRP after a precharge (5) to the same bank, tRP after a precharge-all (6) to the same rank, tRC after an activate to the same bank, and tRFC after a refresh (7) to the same rank.
- R3: An activate waits WREC + tRP after a write with auto-precharge (4) to the same bank.
- R4: Four activates are remembered per rank. A fifth activate to that rank waits until tFAW cycles after the oldest of the four.
- R5: A read (1 or 2) waits tWL + BL/2 + tWTR after any write (3 or 4) on the channel.
- R6: A write (3 or 4) waits tRL + BL/2 + 2 − tWL after any read (1 or 2) on the channel, and tCCD after any write on the channel.
- R7: A precharge (5) waits tRAS after an activate, tRTP after a read (1 or 2), and WREC after a write (3 or 4), each to the same bank.
- R8: A precharge-all (6) waits tRAS after the rank's last activate, tRTP after its last read (1 or 2), and WREC after its last write (3 or 4).
- R9: A refresh (7) waits the following, each on the same rank:
  - tRC after an activate;
  - tRTP + tRP after a read with auto-precharge (2);
  - WREC + tRP after a write with auto-precharge (4);
  - tRP after a precharge (5) or precharge-all (6);
  - tRFC after a refresh.
- R10: A command logged in cycle k contributes max(0, t − j) to a query in cycle k + j. The delay is the maximum over all contributions, so with no new inserts a nonzero delay falls by exactly one per cycle.
- R11: Per-bank rules do not act on other banks, and per-rank rules do not act on other ranks.
- R12: A query sees only commands logged in earlier cycles. A command inserted in the same cycle as a query does not affect that query's result.
- R13: Values on the insert command, rank and bank inputs have no effect while `insert_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insert_valid | input | 1 | Log the insert command this cycle |
| insert_cmd | input | 3 | Command code being issued |
| insert_rank | input | RW | Rank of the issued command |
| insert_bank | input | BKW | Bank of the issued command |
| query_cmd | input | 3 | Candidate command code |
| query_rank | input | RW | Candidate rank |
| query_bank | input | BKW | Candidate bank |
| delay | output | AW | Cycles until the candidate becomes legal |

## Verification
The insert and the query can fall in the same cycle, and can name the same rank and bank. The bench provokes this both with a directed activate that is inserted and queried together and with the random mix, where about a third of the cycles carry an insert. It judges the result against a reference model that applies the insert only after comparing the query. A correct design must therefore return the pre-insert delay in that cycle and the new constraint from the next cycle onward.

// File: rtl/ddr3_tc_pkg.sv
// Shared command codes and helpers for the DDR3 command timing checker.
// Assumes: commands are encoded in three bits as listed in tc_cmd_e.
package ddr3_tc_pkg;

    typedef enum logic [2:0] {
        CMD_ACT  = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDA  = 3'd2,
        CMD_WR   = 3'd3,
        CMD_WRA  = 3'd4,
        CMD_PRE  = 3'd5,
        CMD_PREA = 3'd6,
        CMD_REFA = 3'd7
    } tc_cmd_e;

    // Larger of two integers, used to size the age counters.
    function automatic int tc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr3_tc_age.sv
// Saturating age counter: cycles since the last hit.
// Assumes: reset leaves it saturated, which means "no constraint".
module ddr3_tc_age #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    output logic [AW-1:0] age
);

    // Restart on a hit, otherwise count up until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '1;
        else if (hit)
            age <= '0;
        else if (age != '1)
            age <= age + 1'b1;
    end

endmodule

// File: rtl/ddr3_tc_faw.sv
// Rolling window of activate ages for one rank; exposes the oldest entry.
// Assumes: unused slots stay saturated, so they never constrain.
module ddr3_tc_faw #(
    parameter int AW    = 6,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    output logic [AW-1:0] oldest
);

    logic [AW-1:0] win [DEPTH];

    // Saturating increment of one age value.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
        return (a == '1) ? a : a + 1'b1;
    endfunction

    // Shift a fresh entry in on an activate; age every entry each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                win[i] <= '1;
        end else if (hit) begin
            win[0] <= '0;
            for (int i = 1; i < DEPTH; i++)
                win[i] <= bump(win[i-1]);
        end else begin
            for (int i = 0; i < DEPTH; i++)
                win[i] <= bump(win[i]);
        end
    end

    assign oldest = win[DEPTH-1];

endmodule

// File: rtl/ddr3_tc_eval.sv
// Combinational rule evaluator: picks the ages that matter for the
// candidate command and returns the largest remaining wait.
// Assumes: an age of a means the command was logged a + 1 cycles ago.
module ddr3_tc_eval
    import ddr3_tc_pkg::*;
#(
    parameter int NB    = 16,
    parameter int NR    = 2,
    parameter int AW    = 6,
    parameter int SW    = 4,
    parameter int RW    = 1,
    parameter int T_RP  = 6,
    parameter int T_RC  = 20,
    parameter int T_RFC = 44,
    parameter int T_RAS = 14,
    parameter int T_RTP = 4,
    parameter int T_WL  = 5,
    parameter int T_RL  = 6,
    parameter int T_WR  = 6,
    parameter int T_WTR = 4,
    parameter int T_CCD = 4,
    parameter int T_FAW = 16,
    parameter int BL    = 8
) (
    input  logic [2:0]            q_cmd,
    input  logic [RW-1:0]         q_rank,
    input  logic [SW-1:0]         q_slot,
    input  logic [NB-1:0][AW-1:0] b_act,
    input  logic [NB-1:0][AW-1:0] b_pre,
    input  logic [NB-1:0][AW-1:0] b_rd,
    input  logic [NB-1:0][AW-1:0] b_wr,
    input  logic [NB-1:0][AW-1:0] b_wra,
    input  logic [NR-1:0][AW-1:0] r_act,
    input  logic [NR-1:0][AW-1:0] r_rd,
    input  logic [NR-1:0][AW-1:0] r_rda,
    input  logic [NR-1:0][AW-1:0] r_wr,
    input  logic [NR-1:0][AW-1:0] r_wra,
    input  logic [NR-1:0][AW-1:0] r_pre,
    input  logic [NR-1:0][AW-1:0] r_prea,
    input  logic [NR-1:0][AW-1:0] r_refa,
    input  logic [NR-1:0][AW-1:0] r_faw,
    input  logic [AW-1:0]         g_rd,
    input  logic [AW-1:0]         g_wr,
    output logic [AW-1:0]         delay
);

    localparam int HALF_BL  = BL / 2;
    localparam int K_WREC   = T_WL + HALF_BL + T_WR;
    localparam int K_WR2RD  = T_WL + HALF_BL + T_WTR;
    localparam int K_RD2WR  = T_RL + HALF_BL + 2 - T_WL;
    localparam int K_WRA2RP = K_WREC + T_RP;
    localparam int K_RDA2RP = T_RTP + T_RP;
    localparam int NT       = 6;

    tc_cmd_e       cmd;
    logic [AW-1:0] term [NT];

    assign cmd = tc_cmd_e'(q_cmd);

    // Remaining wait for one rule given the age of its history entry.
    function automatic logic [AW-1:0] rem(input logic [AW-1:0] a, input int t);
        int el;
        el = int'(a) + 1;
        return (el >= t) ? '0 : AW'(t - el);
    endfunction

    // Gather the applicable rules, then take their maximum.
    always_comb begin
        for (int i = 0; i < NT; i++)
            term[i] = '0;
        unique case (cmd)
            CMD_ACT: begin
                term[0] = rem(b_pre[q_slot],   T_RP);
                term[1] = rem(r_prea[q_rank],  T_RP);
                term[2] = rem(b_act[q_slot],   T_RC);
                term[3] = rem(r_refa[q_rank],  T_RFC);
                term[4] = rem(b_wra[q_slot],   K_WRA2RP);
                term[5] = rem(r_faw[q_rank],   T_FAW);
            end
            CMD_RD, CMD_RDA: begin
                term[0] = rem(g_wr, K_WR2RD);
            end
            CMD_WR, CMD_WRA: begin
                term[0] = rem(g_rd, K_RD2WR);
                term[1] = rem(g_wr, T_CCD);
            end
            CMD_PRE: begin
                term[0] = rem(b_act[q_slot], T_RAS);
                term[1] = rem(b_rd[q_slot],  T_RTP);
                term[2] = rem(b_wr[q_slot],  K_WREC);
            end
            CMD_PREA: begin
                term[0] = rem(r_act[q_rank], T_RAS);
                term[1] = rem(r_rd[q_rank],  T_RTP);
                term[2] = rem(r_wr[q_rank],  K_WREC);
            end
            CMD_REFA: begin
                term[0] = rem(r_act[q_rank],  T_RC);
                term[1] = rem(r_rda[q_rank],  K_RDA2RP);
                term[2] = rem(r_wra[q_rank],  K_WRA2RP);
                term[3] = rem(r_pre[q_rank],  T_RP);
                term[4] = rem(r_prea[q_rank], T_RP);
                term[5] = rem(r_refa[q_rank], T_RFC);
            end
            default: ;
        endcase
        delay = '0;
        for (int i = 0; i < NT; i++)
            if (term[i] > delay)
                delay = term[i];
    end

endmodule

// File: rtl/ddr3_cmd_timer.sv
// DDR3 command timing checker top. Logs issued commands into per-bank,
// per-rank and channel-wide age counters and reports, for a candidate
// command, the cycles until it is legal.
// Assumes: query and insert rank/bank values are in range; a query sees
// only commands inserted in earlier cycles.
module ddr3_cmd_timer
    import ddr3_tc_pkg::*;
#(
    parameter int RANKS      = 2,
    parameter int BANKS      = 8,
    parameter int ACT_WINDOW = 4,
    parameter int T_RP       = 6,
    parameter int T_RC       = 20,
    parameter int T_RFC      = 44,
    parameter int T_RAS      = 14,
    parameter int T_RTP      = 4,
    parameter int T_WL       = 5,
    parameter int T_RL       = 6,
    parameter int T_WR       = 6,
    parameter int T_WTR      = 4,
    parameter int T_CCD      = 4,
    parameter int T_FAW      = 16,
    parameter int BL         = 8,
    localparam int RW   = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BKW  = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int MAXT = tc_max(tc_max(tc_max(T_RFC, T_RC),
                                        tc_max(T_WL + BL/2 + T_WR + T_RP, T_FAW)),
                                 tc_max(tc_max(T_WL + BL/2 + T_WTR, T_RL + BL/2 + 2 - T_WL),
                                        tc_max(T_RAS, tc_max(T_RTP + T_RP, T_CCD)))),
    localparam int AW   = $clog2(MAXT + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           insert_valid,
    input  logic [2:0]     insert_cmd,
    input  logic [RW-1:0]  insert_rank,
    input  logic [BKW-1:0] insert_bank,
    input  logic [2:0]     query_cmd,
    input  logic [RW-1:0]  query_rank,
    input  logic [BKW-1:0] query_bank,
    output logic [AW-1:0]  delay
);

    localparam int NB = RANKS * BANKS;
    localparam int SW = (NB > 1) ? $clog2(NB) : 1;

    tc_cmd_e       icmd;
    logic          is_act, is_rd, is_rda, is_wr, is_wra, is_pre, is_prea, is_refa;
    logic [SW-1:0] ins_slot, q_slot;

    logic [NB-1:0][AW-1:0]    b_act, b_pre, b_rd, b_wr, b_wra;
    logic [RANKS-1:0][AW-1:0] r_act, r_rd, r_rda, r_wr, r_wra, r_pre, r_prea, r_refa, r_faw;
    logic [AW-1:0]            g_rd, g_wr;

    // Decode the logged command; nothing is decoded while insert_valid is low.
    always_comb begin
        icmd    = tc_cmd_e'(insert_cmd);
        is_act  = insert_valid && (icmd == CMD_ACT);
        is_rd   = insert_valid && (icmd == CMD_RD);
        is_rda  = insert_valid && (icmd == CMD_RDA);
        is_wr   = insert_valid && (icmd == CMD_WR);
        is_wra  = insert_valid && (icmd == CMD_WRA);
        is_pre  = insert_valid && (icmd == CMD_PRE);
        is_prea = insert_valid && (icmd == CMD_PREA);
        is_refa = insert_valid && (icmd == CMD_REFA);
    end

    // Flat bank slot index: rank-major, bank-minor.
    assign ins_slot = SW'(insert_rank) * SW'(BANKS) + SW'(insert_bank);
    assign q_slot   = SW'(query_rank)  * SW'(BANKS) + SW'(query_bank);

    // Per-bank history.
    for (genvar gb = 0; gb < NB; gb++) begin : g_bank
        logic sel;
        assign sel = (ins_slot == SW'(gb));
        ddr3_tc_age #(.AW(AW)) u_act (.clk(clk), .rst_n(rst_n), .hit(sel && is_act),
                                      .age(b_act[gb]));
        ddr3_tc_age #(.AW(AW)) u_pre (.clk(clk), .rst_n(rst_n), .hit(sel && is_pre),
                                      .age(b_pre[gb]));
        ddr3_tc_age #(.AW(AW)) u_rd  (.clk(clk), .rst_n(rst_n), .hit(sel && (is_rd || is_rda)),
                                      .age(b_rd[gb]));
        ddr3_tc_age #(.AW(AW)) u_wr  (.clk(clk), .rst_n(rst_n), .hit(sel && (is_wr || is_wra)),
                                      .age(b_wr[gb]));
        ddr3_tc_age #(.AW(AW)) u_wra (.clk(clk), .rst_n(rst_n), .hit(sel && is_wra),
                                      .age(b_wra[gb]));
    end

    // Per-rank history, including the activate window.
    for (genvar gr = 0; gr < RANKS; gr++) begin : g_rank
        logic sel;
        assign sel = (insert_rank == RW'(gr));
        ddr3_tc_age #(.AW(AW)) u_act  (.clk(clk), .rst_n(rst_n), .hit(sel && is_act),
                                       .age(r_act[gr]));
        ddr3_tc_age #(.AW(AW)) u_rd   (.clk(clk), .rst_n(rst_n), .hit(sel && (is_rd || is_rda)),
                                       .age(r_rd[gr]));
        ddr3_tc_age #(.AW(AW)) u_rda  (.clk(clk), .rst_n(rst_n), .hit(sel && is_rda),
                                       .age(r_rda[gr]));
        ddr3_tc_age #(.AW(AW)) u_wr   (.clk(clk), .rst_n(rst_n), .hit(sel && (is_wr || is_wra)),
                                       .age(r_wr[gr]));
        ddr3_tc_age #(.AW(AW)) u_wra  (.clk(clk), .rst_n(rst_n), .hit(sel && is_wra),
                                       .age(r_wra[gr]));
        ddr3_tc_age #(.AW(AW)) u_pre  (.clk(clk), .rst_n(rst_n), .hit(sel && is_pre),
                                       .age(r_pre[gr]));
        ddr3_tc_age #(.AW(AW)) u_prea (.clk(clk), .rst_n(rst_n), .hit(sel && is_prea),
                                       .age(r_prea[gr]));
        ddr3_tc_age #(.AW(AW)) u_refa (.clk(clk), .rst_n(rst_n), .hit(sel && is_refa),
                                       .age(r_refa[gr]));
        ddr3_tc_faw #(.AW(AW), .DEPTH(ACT_WINDOW)) u_faw (.clk(clk), .rst_n(rst_n),
                                       .hit(sel && is_act), .oldest(r_faw[gr]));
    end

    // Channel-wide read/write turnaround history.
    ddr3_tc_age #(.AW(AW)) u_g_rd (.clk(clk), .rst_n(rst_n), .hit(is_rd || is_rda), .age(g_rd));
    ddr3_tc_age #(.AW(AW)) u_g_wr (.clk(clk), .rst_n(rst_n), .hit(is_wr || is_wra), .age(g_wr));

    // Rule evaluation for the candidate command.
    ddr3_tc_eval #(
        .NB(NB), .NR(RANKS), .AW(AW), .SW(SW), .RW(RW),
        .T_RP(T_RP), .T_RC(T_RC), .T_RFC(T_RFC), .T_RAS(T_RAS), .T_RTP(T_RTP),
        .T_WL(T_WL), .T_RL(T_RL), .T_WR(T_WR), .T_WTR(T_WTR), .T_CCD(T_CCD),
        .T_FAW(T_FAW), .BL(BL)
    ) u_eval (
        .q_cmd(query_cmd), .q_rank(query_rank), .q_slot(q_slot),
        .b_act(b_act), .b_pre(b_pre), .b_rd(b_rd), .b_wr(b_wr), .b_wra(b_wra),
        .r_act(r_act), .r_rd(r_rd), .r_rda(r_rda), .r_wr(r_wr), .r_wra(r_wra),
        .r_pre(r_pre), .r_prea(r_prea), .r_refa(r_refa), .r_faw(r_faw),
        .g_rd(g_rd), .g_wr(g_wr), .delay(delay)
    );

endmodule

// File: rtl/ddr3_cmd_timer_chk.sv
// Property checker for ddr3_cmd_timer, attached by bind. Observes ports only.
module ddr3_cmd_timer_chk
    import ddr3_tc_pkg::*;
#(
    parameter int RW      = 1,
    parameter int BKW     = 3,
    parameter int DW      = 6,
    parameter int T_RC    = 20,
    parameter int T_RFC   = 44,
    parameter int T_CCD   = 4,
    parameter int K_WR2RD = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           insert_valid,
    input logic [2:0]     insert_cmd,
    input logic [RW-1:0]  insert_rank,
    input logic [BKW-1:0] insert_bank,
    input logic [2:0]     query_cmd,
    input logic [RW-1:0]  query_rank,
    input logic [BKW-1:0] query_bank,
    input logic [DW-1:0]  delay
);

    logic seen;

    // Marks cycles that have a post-reset predecessor for $past.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> delay == '0);

    a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(insert_valid) && $past(delay) != '0 &&
         $stable(query_cmd) && $stable(query_rank) && $stable(query_bank))
        |-> delay == $past(delay) - 1'b1);

    a_r2_act_rc: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(insert_valid) && $past(insert_cmd) == CMD_ACT &&
         query_cmd == CMD_ACT && query_rank == $past(insert_rank) &&
         query_bank == $past(insert_bank))
        |-> int'(delay) >= T_RC - 1);

    a_r5_wr_to_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(insert_valid) &&
         ($past(insert_cmd) == CMD_WR || $past(insert_cmd) == CMD_WRA) &&
         (query_cmd == CMD_RD || query_cmd == CMD_RDA))
        |-> int'(delay) >= K_WR2RD - 1);

    a_r6_wr_ccd: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(insert_valid) &&
         ($past(insert_cmd) == CMD_WR || $past(insert_cmd) == CMD_WRA) &&
         (query_cmd == CMD_WR || query_cmd == CMD_WRA))
        |-> int'(delay) >= T_CCD - 1);

    a_r9_refa_rfc: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(insert_valid) && $past(insert_cmd) == CMD_REFA &&
         query_cmd == CMD_REFA && query_rank == $past(insert_rank))
        |-> int'(delay) >= T_RFC - 1);

endmodule

bind ddr3_cmd_timer ddr3_cmd_timer_chk #(
    .RW(RW), .BKW(BKW), .DW(AW), .T_RC(T_RC), .T_RFC(T_RFC), .T_CCD(T_CCD),
    .K_WR2RD(T_WL + BL/2 + T_WTR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .insert_valid(insert_valid), .insert_cmd(insert_cmd),
    .insert_rank(insert_rank), .insert_bank(insert_bank), .query_cmd(query_cmd),
    .query_rank(query_rank), .query_bank(query_bank), .delay(delay)
);

// File: tb/ddr3_cmd_timer_bench.sv
`timescale 1ns/1ps
module ddr3_cmd_timer_bench;

    localparam int NR = 2, NBK = 8, NB = NR * NBK;
    localparam int T_RP = 6, T_RC = 20, T_RFC = 44, T_RAS = 14, T_RTP = 4;
    localparam int T_WL = 5, T_RL = 6, T_WR = 6, T_WTR = 4, T_CCD = 4;
    localparam int T_FAW = 16, BL = 8;
    localparam int WREC = T_WL + BL/2 + T_WR;
    localparam int DW = 6;

    localparam logic [2:0] ACT = 3'd0, RD = 3'd1, RDA = 3'd2, WR = 3'd3,
                           WRA = 3'd4, PRE = 3'd5, PREA = 3'd6, REFA = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_v = 1'b0;
    logic [2:0]    ins_c = '0;
    logic [0:0]    ins_r = '0;
    logic [2:0]    ins_b = '0;
    logic [2:0]    q_c = '0;
    logic [0:0]    q_r = '0;
    logic [2:0]    q_b = '0;
    logic [DW-1:0] dly;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    // Reference history: issue cycle of the last command, -1 when never.
    int lb_act[NB], lb_pre[NB], lb_rd[NB], lb_wr[NB], lb_wra[NB];
    int lr_act[NR], lr_rd[NR], lr_rda[NR], lr_wr[NR], lr_wra[NR];
    int lr_pre[NR], lr_prea[NR], lr_refa[NR];
    int faw[NR][4];
    int lg_rd, lg_wr;

    always #2 clk = ~clk;

    ddr3_cmd_timer #(
        .RANKS(NR), .BANKS(NBK), .T_RP(T_RP), .T_RC(T_RC), .T_RFC(T_RFC),
        .T_RAS(T_RAS), .T_RTP(T_RTP), .T_WL(T_WL), .T_RL(T_RL), .T_WR(T_WR),
        .T_WTR(T_WTR), .T_CCD(T_CCD), .T_FAW(T_FAW), .BL(BL)
    ) u_ddr3_cmd_timer (
        .clk(clk), .rst_n(rst_n), .insert_valid(ins_v), .insert_cmd(ins_c),
        .insert_rank(ins_r), .insert_bank(ins_b), .query_cmd(q_c),
        .query_rank(q_r), .query_bank(q_b), .delay(dly)
    );

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Remaining wait of one rule in the current cycle.
    function automatic int rem(input int last, input int t);
        if (last < 0) return 0;
        return mx(0, last + t - cyc);
    endfunction

    function automatic int model_delay(input logic [2:0] c, input int r, input int b);
        int s, d;
        s = r * NBK + b;
        d = 0;
        case (c)
            ACT: begin
                d = mx(d, rem(lb_pre[s], T_RP));
                d = mx(d, rem(lr_prea[r], T_RP));
                d = mx(d, rem(lb_act[s], T_RC));
                d = mx(d, rem(lr_refa[r], T_RFC));
                d = mx(d, rem(lb_wra[s], WREC + T_RP));
                d = mx(d, rem(faw[r][3], T_FAW));
            end
            RD, RDA: d = rem(lg_wr, T_WL + BL/2 + T_WTR);
            WR, WRA: d = mx(rem(lg_rd, T_RL + BL/2 + 2 - T_WL), rem(lg_wr, T_CCD));
            PRE: begin
                d = mx(d, rem(lb_act[s], T_RAS));
                d = mx(d, rem(lb_rd[s], T_RTP));
                d = mx(d, rem(lb_wr[s], WREC));
            end
            PREA: begin
                d = mx(d, rem(lr_act[r], T_RAS));
                d = mx(d, rem(lr_rd[r], T_RTP));
                d = mx(d, rem(lr_wr[r], WREC));
            end
            default: begin
                d = mx(d, rem(lr_act[r], T_RC));
                d = mx(d, rem(lr_rda[r], T_RTP + T_RP));
                d = mx(d, rem(lr_wra[r], WREC + T_RP));
                d = mx(d, rem(lr_pre[r], T_RP));
                d = mx(d, rem(lr_prea[r], T_RP));
                d = mx(d, rem(lr_refa[r], T_RFC));
            end
        endcase
        return d;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NB; i++) begin
            lb_act[i] = -1; lb_pre[i] = -1; lb_rd[i] = -1; lb_wr[i] = -1; lb_wra[i] = -1;
        end
        for (int i = 0; i < NR; i++) begin
            lr_act[i] = -1; lr_rd[i] = -1; lr_rda[i] = -1; lr_wr[i] = -1; lr_wra[i] = -1;
            lr_pre[i] = -1; lr_prea[i] = -1; lr_refa[i] = -1;
            for (int k = 0; k < 4; k++) faw[i][k] = -1;
        end
        lg_rd = -1; lg_wr = -1;
    endtask

    task automatic model_insert(input logic [2:0] c, input int r, input int b);
        int s;
        s = r * NBK + b;
        case (c)
            ACT: begin
                lb_act[s] = cyc; lr_act[r] = cyc;
                for (int k = 3; k > 0; k--) faw[r][k] = faw[r][k-1];
                faw[r][0] = cyc;
            end
            RD, RDA: begin
                lb_rd[s] = cyc; lr_rd[r] = cyc; lg_rd = cyc;
                if (c == RDA) lr_rda[r] = cyc;
            end
            WR, WRA: begin
                lb_wr[s] = cyc; lr_wr[r] = cyc; lg_wr = cyc;
                if (c == WRA) begin lb_wra[s] = cyc; lr_wra[r] = cyc; end
            end
            PRE:  begin lb_pre[s] = cyc; lr_pre[r] = cyc; end
            PREA: lr_prea[r] = cyc;
            default: lr_refa[r] = cyc;
        endcase
    endtask

    // One cycle: drive, compare the query against the model, then log the insert.
    task automatic step(input logic iv, input logic [2:0] ic, input int ir, input int ib,
                        input logic [2:0] qc, input int qr, input int qb, input string tag);
        int exp;
        @(negedge clk);
        ins_v = iv; ins_c = ic; ins_r = 1'(ir); ins_b = 3'(ib);
        q_c = qc; q_r = 1'(qr); q_b = 3'(qb);
        #1;
        exp = model_delay(qc, qr, qb);
        checks++;
        if (int'(dly) != exp) begin
            errors++;
            $display("FAIL %s: cmd=%0d rank=%0d bank=%0d delay=%0d expected=%0d",
                     tag, qc, qr, qb, dly, exp);
        end
        @(posedge clk);
        if (iv) model_insert(ic, ir, ib);
        cyc++;
    endtask

    task automatic idle(input int n, input logic [2:0] qc, input int qr, input int qb,
                        input string tag);
        for (int i = 0; i < n; i++) step(1'b0, ACT, 0, 0, qc, qr, qb, tag);
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state, every command code answers zero.
        for (int c = 0; c < 8; c++) step(1'b0, ACT, 0, 0, 3'(c), c % 2, c, "R1");

        // R13: insert inputs ignored while insert_valid is low.
        step(1'b0, ACT, 0, 5, ACT, 0, 5, "R13");
        step(1'b0, REFA, 0, 5, ACT, 0, 5, "R13");
        step(1'b0, WR, 0, 5, RD, 0, 5, "R13");

        // R12 then R2: same-cycle insert and query, then tRC countdown.
        step(1'b1, ACT, 0, 1, ACT, 0, 1, "R12");
        idle(3, ACT, 0, 1, "R2");
        step(1'b0, ACT, 0, 0, ACT, 0, 2, "R11");
        step(1'b0, ACT, 0, 0, ACT, 1, 1, "R11");
        idle(T_RC, ACT, 0, 1, "R10");
        step(1'b1, PRE, 0, 1, PRE, 0, 1, "R12");
        idle(T_RP + 1, ACT, 0, 1, "R2");
        step(1'b1, PREA, 1, 0, ACT, 1, 3, "R2");
        idle(T_RP + 1, ACT, 1, 3, "R2");
        step(1'b1, REFA, 1, 0, ACT, 1, 0, "R2");
        idle(4, ACT, 1, 0, "R2");
        idle(4, REFA, 1, 0, "R9");
        idle(70, ACT, 1, 0, "R10");

        // R3: activate after write with auto-precharge.
        step(1'b1, WRA, 0, 2, ACT, 0, 2, "R3");
        idle(WREC + T_RP + 2, ACT, 0, 2, "R3");
        step(1'b0, ACT, 0, 0, ACT, 0, 3, "R11");

        // R4: four-activate window.
        idle(70, ACT, 1, 5, "R10");
        for (int b = 0; b < 4; b++) step(1'b1, ACT, 1, b, ACT, 1, 5, "R4");
        idle(T_FAW, ACT, 1, 5, "R4");
        step(1'b0, ACT, 0, 0, ACT, 0, 5, "R11");

        // R5, R6: channel-wide turnaround.
        idle(70, RD, 1, 7, "R10");
        step(1'b1, WR, 0, 0, RD, 1, 7, "R5");
        idle(T_WL + BL/2 + T_WTR + 1, RDA, 1, 7, "R5");
        step(1'b1, WR, 0, 3, WR, 1, 2, "R6");
        idle(T_CCD + 1, WRA, 1, 2, "R6");
        step(1'b1, RD, 1, 4, WR, 0, 0, "R6");
        idle(T_RL + BL/2 + 3 - T_WL, WR, 0, 0, "R6");

        // R7: precharge one bank.
        idle(70, PRE, 0, 6, "R10");
        step(1'b1, ACT, 0, 6, PRE, 0, 6, "R7");
        idle(T_RAS + 1, PRE, 0, 6, "R7");
        step(1'b1, WR, 0, 6, PRE, 0, 6, "R7");
        idle(WREC + 1, PRE, 0, 6, "R7");
        step(1'b1, RDA, 0, 6, PRE, 0, 6, "R7");
        idle(T_RTP + 1, PRE, 0, 6, "R7");

        // R8: precharge all banks of a rank.
        idle(70, PREA, 1, 0, "R10");
        step(1'b1, ACT, 1, 7, PREA, 1, 0, "R8");
        idle(T_RAS + 1, PREA, 1, 0, "R8");
        step(1'b1, WRA, 1, 3, PREA, 1, 0, "R8");
        idle(3, PREA, 0, 0, "R11");
        idle(WREC, PREA, 1, 0, "R8");

        // R9: refresh after auto-precharge reads/writes and precharges.
        idle(70, REFA, 0, 0, "R10");
        step(1'b1, RDA, 0, 4, REFA, 0, 0, "R9");
        idle(T_RTP + T_RP + 1, REFA, 0, 0, "R9");
        step(1'b1, WRA, 0, 1, REFA, 0, 0, "R9");
        idle(WREC + T_RP + 1, REFA, 0, 0, "R9");
        step(1'b1, PRE, 0, 2, REFA, 0, 0, "R9");
        idle(T_RP + 1, REFA, 0, 0, "R9");

        // R10: random mix with a fixed seed, plus same-cycle overlaps (R12).
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic iv;
            iv = ($urandom % 3) == 0;
            step(iv, 3'($urandom % 8), int'($urandom % NR), int'($urandom % NBK),
                 3'($urandom % 8), int'($urandom % NR), int'($urandom % NBK), "R10");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected=finish", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule